// File: doc/BRIEF.md
# Priority-Ordered Peripheral Pin Crossbar

This block places a fixed, ranked set of on-chip peripheral signals onto a bank of general-purpose port pins. Signals are handled from the highest rank downwards. Each requesting signal takes the lowest-numbered pin that is free, and software can mark pins as reserved so that the allocator steps over them. A reserved pin might hold an analog input, for example. Any pin that no signal claims stays under plain GPIO control.

Each pin also has a digital/analog input mode and an open-drain/push-pull output mode. The block turns these, together with the value and enable from the pin's owner, into the pad controls. It also returns the digital read value of each pin, and each placed peripheral gets the read value of its own pin. All configuration inputs are registered once. The allocation is computed from the live configuration and captured at the next clock edge, which keeps the long priority chain out of the pad paths.

Top module: `xbar_crossbar`

## Requirements
- R1: Signals are ranked by index, from 0 (highest) to 23 (lowest): UART transmit, UART receive, SPI clock, SPI MISO, SPI MOSI, SPI slave select (index 5), I2C data, I2C clock, comparator 0 sync and async outputs, comparator 1 sync and async outputs, system clock, counter channels 0 to 5, counter external clock (index 19), timer 0 (index 20), timer 1, LIN transmit and LIN receive (index 23). Each requesting signal, taken in rank order, is given the lowest-numbered pin that is not reserved and not already given away.
- R2: A pin whose `pin_skip` bit is 1 is never given to a signal and is driven from `gpio_out`.
- R3: While `xbar_en` is 0, no signal holds a pin, `sig_unplaced` is 0 and `periph_in` is 0.
- R4: Signal 5 (SPI slave select) requests a pin only when `spi_four_wire` is 1.
- R5: While reset is held, every pin is in digital mode and open-drain mode and no signal holds a pin.
- R6: For a pin in analog mode (`pin_digital` bit 0), `pad_oe`, `pad_pu`, `pad_out` and `pin_read` are all 0.
- R7: For a digital pin in push-pull mode, `pad_out` equals the source value and `pad_oe` equals the source enable. For a digital pin in open-drain mode, `pad_out` is 0, and `pad_oe` is 1 only when the source is enabled and its value is 0.
- R8: `sig_unplaced[s]` is 1 exactly when signal s requests a pin and no eligible pin is left for it.
- R9: A change on `xbar_en`, `spi_four_wire`, `sig_en`, `pin_skip`, `pin_digital` or `pin_pushpull` shows at the outputs one clock after it is sampled, never in the same cycle.
- R10: `periph_in[s]` equals `pin_read` of the pin that signal s holds. It is 0 when signal s holds no pin.
- R11: A claimed pin takes its source value and enable from `periph_out` and `periph_oe` of its owner. An unclaimed pin takes `gpio_out` as its value, with the enable held at 1. `pad_pu` equals the pin's digital mode bit, and `pin_read` is `pad_in` masked by that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xbar_en | input | 1 | Global allocation enable |
| spi_four_wire | input | 1 | SPI slave select takes part when 1 |
| sig_en | input | 24 | Per-signal request enable, indexed by rank |
| pin_skip | input | 25 | Per-pin reserve bit |
| pin_digital | input | 25 | Per-pin input mode, 1 digital, 0 analog |
| pin_pushpull | input | 25 | Per-pin output mode, 1 push-pull, 0 open-drain |
| gpio_out | input | 25 | GPIO value for unclaimed pins |
| periph_out | input | 24 | Per-signal output value |
| periph_oe | input | 24 | Per-signal drive request |
| pad_in | input | 25 | Level seen at each pad |
| pad_out | output | 25 | Pad drive value |
| pad_oe | output | 25 | Pad driver enable |
| pad_pu | output | 25 | Weak pull-up enable |
| pin_read | output | 25 | Digital read value per pin |
| periph_in | output | 24 | Read value delivered to each signal |
| sig_unplaced | output | 24 | Signal requested a pin but none was left |

## Verification
The assertions compare the outputs in each cycle with the configuration sampled at the previous edge. So they assume that every configuration input is a clean, known level at each rising edge, and they arm only one cycle after reset is released. The live data inputs (`gpio_out`, `periph_out`, `periph_oe`, `pad_in`) need no such assumption. The bench changes all inputs only 1 ns after a rising edge and then holds each configuration for two full cycles. This way both the one-cycle delay and the settled result are checked before anything moves again.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

    // Rank order of the routable signals; the enum value is the priority index.
    typedef enum logic [4:0] {
        SIG_UART_TX, SIG_UART_RX, SIG_SPI_CLK, SIG_SPI_MISO, SIG_SPI_MOSI,
        SIG_SPI_SEL, SIG_I2C_SDA, SIG_I2C_SCL, SIG_CMP0_S, SIG_CMP0_A,
        SIG_CMP1_S, SIG_CMP1_A, SIG_SYS_CLK, SIG_CNT_CH0, SIG_CNT_CH1,
        SIG_CNT_CH2, SIG_CNT_CH3, SIG_CNT_CH4, SIG_CNT_CH5, SIG_CNT_EXT,
        SIG_TMR0, SIG_TMR1, SIG_LIN_TX, SIG_LIN_RX
    } xb_sig_e;

    localparam int unsigned XB_NUM_SIGS = int'(SIG_LIN_RX) + 1;
    localparam int unsigned XB_SEL_IDX  = int'(SIG_SPI_SEL);

endpackage

// File: rtl/xbar_alloc.sv
module xbar_alloc #(
    parameter int unsigned NUM_PINS = 25,
    parameter int unsigned NUM_SIGS = 24,
    localparam int unsigned PIN_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1,
    localparam int unsigned SIG_W   = (NUM_SIGS > 1) ? $clog2(NUM_SIGS) : 1
) (
    input  logic [NUM_SIGS-1:0]             req,
    input  logic [NUM_PINS-1:0]             reserved,
    output logic [NUM_PINS-1:0]             claimed,
    output logic [NUM_PINS-1:0][SIG_W-1:0]  owner,
    output logic [NUM_SIGS-1:0]             placed,
    output logic [NUM_SIGS-1:0][PIN_W-1:0]  pin_of
);

    // Walk signals in rank order; each grabs the lowest pin still free.
    always_comb begin
        logic [NUM_PINS-1:0] taken;
        logic                found;
        taken   = reserved;
        claimed = '0;
        owner   = '0;
        placed  = '0;
        pin_of  = '0;
        for (int s = 0; s < int'(NUM_SIGS); s++) begin
            found = 1'b0;
            for (int p = 0; p < int'(NUM_PINS); p++) begin
                if (req[s] && !found && !taken[p]) begin
                    found      = 1'b1;
                    taken[p]   = 1'b1;
                    claimed[p] = 1'b1;
                    owner[p]   = SIG_W'(s);
                    placed[s]  = 1'b1;
                    pin_of[s]  = PIN_W'(p);
                end
            end
        end
    end

endmodule

// File: rtl/xbar_pad_cell.sv
module xbar_pad_cell (
    input  logic is_digital,
    input  logic push_pull,
    input  logic src_val,
    input  logic src_en,
    input  logic pad_in,
    output logic pad_out,
    output logic pad_oe,
    output logic pad_pu,
    output logic rd_val
);

    // Analog mode silences driver, pull-up and receiver together.
    assign pad_pu  = is_digital;
    assign pad_out = is_digital & push_pull & src_val;
    assign pad_oe  = is_digital & src_en & (push_pull | ~src_val);
    assign rd_val  = is_digital & pad_in;

endmodule

// File: rtl/xbar_crossbar.sv
module xbar_crossbar
    import xbar_pkg::*;
#(
    parameter int unsigned NUM_PINS = 25,
    localparam int unsigned NUM_SIGS = XB_NUM_SIGS,
    localparam int unsigned PIN_W    = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1,
    localparam int unsigned SIG_W    = (NUM_SIGS > 1) ? $clog2(NUM_SIGS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                xbar_en,
    input  logic                spi_four_wire,
    input  logic [NUM_SIGS-1:0] sig_en,
    input  logic [NUM_PINS-1:0] pin_skip,
    input  logic [NUM_PINS-1:0] pin_digital,
    input  logic [NUM_PINS-1:0] pin_pushpull,
    input  logic [NUM_PINS-1:0] gpio_out,
    input  logic [NUM_SIGS-1:0] periph_out,
    input  logic [NUM_SIGS-1:0] periph_oe,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic [NUM_PINS-1:0] pad_pu,
    output logic [NUM_PINS-1:0] pin_read,
    output logic [NUM_SIGS-1:0] periph_in,
    output logic [NUM_SIGS-1:0] sig_unplaced
);

    typedef struct packed {
        logic [NUM_PINS-1:0]            dig;
        logic [NUM_PINS-1:0]            pp;
        logic [NUM_PINS-1:0]            claimed;
        logic [NUM_PINS-1:0][SIG_W-1:0] owner;
        logic [NUM_SIGS-1:0]            placed;
        logic [NUM_SIGS-1:0]            unplaced;
        logic [NUM_SIGS-1:0][PIN_W-1:0] pin_of;
    } xb_state_t;

    xb_state_t state_d, state_q;

    logic [NUM_SIGS-1:0]            req_w;
    logic [NUM_SIGS-1:0]            sel_gate_w;
    logic [NUM_PINS-1:0]            claimed_w;
    logic [NUM_PINS-1:0][SIG_W-1:0] owner_w;
    logic [NUM_SIGS-1:0]            placed_w;
    logic [NUM_SIGS-1:0][PIN_W-1:0] pin_of_w;

    // Slave select drops out of the ranking in three-wire mode.
    always_comb begin
        sel_gate_w             = '1;
        sel_gate_w[XB_SEL_IDX] = spi_four_wire;
    end

    assign req_w = {NUM_SIGS{xbar_en}} & sig_en & sel_gate_w;

    xbar_alloc #(
        .NUM_PINS (NUM_PINS),
        .NUM_SIGS (NUM_SIGS)
    ) u_alloc (
        .req      (req_w),
        .reserved (pin_skip),
        .claimed  (claimed_w),
        .owner    (owner_w),
        .placed   (placed_w),
        .pin_of   (pin_of_w)
    );

    always_comb begin
        state_d          = state_q;
        state_d.dig      = pin_digital;
        state_d.pp       = pin_pushpull;
        state_d.claimed  = claimed_w;
        state_d.owner    = owner_w;
        state_d.placed   = placed_w;
        state_d.unplaced = req_w & ~placed_w;
        state_d.pin_of   = pin_of_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= '0;
            state_q.dig <= '1;
        end else begin
            state_q <= state_d;
        end
    end

    for (genvar p = 0; p < int'(NUM_PINS); p++) begin : g_pin
        logic src_val;
        logic src_en;
        assign src_val = state_q.claimed[p] ? periph_out[state_q.owner[p]] : gpio_out[p];
        assign src_en  = state_q.claimed[p] ? periph_oe[state_q.owner[p]]  : 1'b1;

        xbar_pad_cell u_cell (
            .is_digital (state_q.dig[p]),
            .push_pull  (state_q.pp[p]),
            .src_val    (src_val),
            .src_en     (src_en),
            .pad_in     (pad_in[p]),
            .pad_out    (pad_out[p]),
            .pad_oe     (pad_oe[p]),
            .pad_pu     (pad_pu[p]),
            .rd_val     (pin_read[p])
        );
    end

    for (genvar s = 0; s < int'(NUM_SIGS); s++) begin : g_sig
        assign periph_in[s] = state_q.placed[s] & pin_read[state_q.pin_of[s]];
    end

    assign sig_unplaced = state_q.unplaced;

endmodule

// File: rtl/xbar_crossbar_chk.sv
module xbar_crossbar_chk
    import xbar_pkg::*;
#(
    parameter int unsigned NUM_PINS = 25,
    parameter int unsigned NUM_SIGS = 24
) (
    input logic                clk,
    input logic                rst_n,
    input logic                xbar_en,
    input logic                spi_four_wire,
    input logic [NUM_SIGS-1:0] sig_en,
    input logic [NUM_PINS-1:0] pin_skip,
    input logic [NUM_PINS-1:0] pin_digital,
    input logic [NUM_PINS-1:0] pin_pushpull,
    input logic [NUM_PINS-1:0] gpio_out,
    input logic [NUM_PINS-1:0] pad_out,
    input logic [NUM_PINS-1:0] pad_oe,
    input logic [NUM_PINS-1:0] pad_pu,
    input logic [NUM_PINS-1:0] pin_read,
    input logic [NUM_SIGS-1:0] periph_in,
    input logic [NUM_SIGS-1:0] sig_unplaced
);

    // Set once a full edge has passed with reset released, so $past is meaningful.
    logic armed_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    p_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && !$past(xbar_en) |-> (sig_unplaced == '0) && (periph_in == '0));

    p_sel_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && !$past(spi_four_wire) |-> !sig_unplaced[XB_SEL_IDX] && !periph_in[XB_SEL_IDX]);

    p_unplaced_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> (sig_unplaced & ~$past(sig_en)) == '0);

    for (genvar p = 0; p < int'(NUM_PINS); p++) begin : g_pin_chk
        p_skip_gpio_r2: assert property (@(posedge clk) disable iff (!rst_n)
            armed_q && $past(pin_skip[p]) && $past(pin_digital[p]) && $past(pin_pushpull[p])
            |-> pad_out[p] == gpio_out[p]);

        p_analog_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
            armed_q && !$past(pin_digital[p]) |-> !pad_oe[p] && !pad_pu[p] && !pin_read[p] && !pad_out[p]);

        p_od_no_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
            armed_q && !$past(pin_pushpull[p]) |-> !pad_out[p]);
    end

endmodule

bind xbar_crossbar xbar_crossbar_chk #(
    .NUM_PINS (NUM_PINS),
    .NUM_SIGS (NUM_SIGS)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .xbar_en       (xbar_en),
    .spi_four_wire (spi_four_wire),
    .sig_en        (sig_en),
    .pin_skip      (pin_skip),
    .pin_digital   (pin_digital),
    .pin_pushpull  (pin_pushpull),
    .gpio_out      (gpio_out),
    .pad_out       (pad_out),
    .pad_oe        (pad_oe),
    .pad_pu        (pad_pu),
    .pin_read      (pin_read),
    .periph_in     (periph_in),
    .sig_unplaced  (sig_unplaced)
);

// File: tb/xbar_crossbar_tb.sv
module xbar_crossbar_tb;
    import xbar_pkg::*;

    localparam int NP = 25;
    localparam int NS = XB_NUM_SIGS;

    typedef struct {
        logic          en;
        logic          four;
        logic [NS-1:0] sen;
        logic [NP-1:0] skip;
        logic [NP-1:0] dig;
        logic [NP-1:0] pp;
    } cfg_t;

    typedef struct {
        logic [NP-1:0] gpo;
        logic [NP-1:0] pin;
        logic [NS-1:0] po;
        logic [NS-1:0] poe;
    } live_t;

    typedef struct {
        int            due;
        string         tag;
        logic [NP-1:0] out;
        logic [NP-1:0] oe;
        logic [NP-1:0] pu;
        logic [NP-1:0] rd;
        logic [NS-1:0] pin_in;
        logic [NS-1:0] unpl;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic          xbar_en, spi_four_wire;
    logic [NS-1:0] sig_en, periph_out, periph_oe, periph_in, sig_unplaced;
    logic [NP-1:0] pin_skip, pin_digital, pin_pushpull, gpio_out, pad_in;
    logic [NP-1:0] pad_out, pad_oe, pad_pu, pin_read;

    always #2 clk = ~clk;

    xbar_crossbar #(.NUM_PINS(NP)) u_dut (
        .clk (clk), .rst_n (rst_n), .xbar_en (xbar_en), .spi_four_wire (spi_four_wire),
        .sig_en (sig_en), .pin_skip (pin_skip), .pin_digital (pin_digital),
        .pin_pushpull (pin_pushpull), .gpio_out (gpio_out), .periph_out (periph_out),
        .periph_oe (periph_oe), .pad_in (pad_in), .pad_out (pad_out), .pad_oe (pad_oe),
        .pad_pu (pad_pu), .pin_read (pin_read), .periph_in (periph_in),
        .sig_unplaced (sig_unplaced)
    );

    int   cyc = 0;
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done = 1'b0;
    exp_t sb[$];
    cfg_t prev;

    always @(posedge clk) cyc <= cyc + 1;

    // Expected outputs from the requirements: pins scanned upward, each
    // non-reserved pin takes the next requesting signal in rank order.
    function automatic exp_t model(cfg_t c, live_t l);
        exp_t          e;
        logic [NS-1:0] req;
        logic [NS-1:0] got;
        int            pin_of [NS];
        int            nxt;
        e.out = '0; e.oe = '0; e.pu = '0; e.rd = '0; e.pin_in = '0; e.unpl = '0;
        e.due = 0; e.tag = "";
        got = '0;
        for (int s = 0; s < NS; s++) begin
            req[s] = c.en && c.sen[s] && (s != 5 || c.four);   // R4: index 5
            pin_of[s] = 0;
        end
        nxt = 0;
        for (int p = 0; p < NP; p++) begin
            logic v, en_src;
            v = l.gpo[p];
            en_src = 1'b1;
            if (!c.skip[p]) begin
                while (nxt < NS && !req[nxt]) nxt++;
                if (nxt < NS) begin
                    v = l.po[nxt];
                    en_src = l.poe[nxt];
                    got[nxt] = 1'b1;
                    pin_of[nxt] = p;
                    nxt++;
                end
            end
            if (c.dig[p]) begin
                e.pu[p]  = 1'b1;
                e.rd[p]  = l.pin[p];
                e.out[p] = c.pp[p] & v;
                e.oe[p]  = en_src & (c.pp[p] | ~v);
            end
        end
        for (int s = 0; s < NS; s++) begin
            e.unpl[s]   = req[s] & ~got[s];
            e.pin_in[s] = got[s] ? e.rd[pin_of[s]] : 1'b0;
        end
        return e;
    endfunction

    task automatic drive(cfg_t c, live_t l);
        xbar_en = c.en; spi_four_wire = c.four; sig_en = c.sen; pin_skip = c.skip;
        pin_digital = c.dig; pin_pushpull = c.pp;
        gpio_out = l.gpo; pad_in = l.pin; periph_out = l.po; periph_oe = l.poe;
    endtask

    // Driver: new inputs 1 ns after an edge. In that cycle the old configuration
    // still rules (R9); one cycle later the new one does.
    task automatic apply(cfg_t c, live_t l, string tag);
        exp_t e;
        @(posedge clk);
        #1;
        drive(c, l);
        e = model(prev, l); e.due = cyc;     e.tag = "R9"; sb.push_back(e);
        e = model(c, l);    e.due = cyc + 1; e.tag = tag;  sb.push_back(e);
        prev = c;
        @(posedge clk);
    endtask

    task automatic cmp(string tag, string fld, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h (cycle %0d)", tag, fld, act, exp, cyc);
        end
    endtask

    // Monitor: pops items due in this cycle, 3 ns after the edge.
    initial begin
        forever begin
            @(posedge clk);
            #3;
            while (sb.size() > 0 && sb[0].due <= cyc) begin
                exp_t e;
                e = sb.pop_front();
                if (e.due < cyc) cmp(e.tag, "missed-slot", 32'(cyc), 32'(e.due));
                cmp(e.tag, "pad_out",      32'(pad_out),      32'(e.out));
                cmp(e.tag, "pad_oe",       32'(pad_oe),       32'(e.oe));
                cmp(e.tag, "pad_pu",       32'(pad_pu),       32'(e.pu));
                cmp(e.tag, "pin_read",     32'(pin_read),     32'(e.rd));
                cmp(e.tag, "periph_in",    32'(periph_in),    32'(e.pin_in));
                cmp(e.tag, "sig_unplaced", 32'(sig_unplaced), 32'(e.unpl));
            end
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        cfg_t  c, rst_cfg;
        live_t l;
        exp_t  e;

        // R5: outputs under reset ignore an all-analog, all-push-pull request.
        rst_cfg.en = 1'b0; rst_cfg.four = 1'b0; rst_cfg.sen = '0; rst_cfg.skip = '0;
        rst_cfg.dig = '1; rst_cfg.pp = '0;
        c.en = 1'b1; c.four = 1'b1; c.sen = '1; c.skip = '0; c.dig = '0; c.pp = '1;
        l.gpo = 25'h0AA_AAAA; l.pin = '1; l.po = 24'h5A_C3F0; l.poe = '1;
        drive(c, l);
        repeat (2) @(posedge clk);
        #1;
        e = model(rst_cfg, l); e.due = cyc; e.tag = "R5"; sb.push_back(e);
        rst_n = 1'b1;
        prev = c;
        @(posedge clk);

        // R1/R11: every signal requested, no reserve: signals on pins 0..23, pin 24 GPIO.
        c.en = 1'b1; c.four = 1'b1; c.sen = '1; c.skip = '0; c.dig = '1; c.pp = '1;
        l.gpo = 25'h1FF_FFFF; l.pin = 25'h0F3_5A96; l.po = 24'hA5_C3_96; l.poe = 24'hFF_0F_F0;
        apply(c, l, "R1");

        // R2/R8: pins 0,2,3,5 reserved, so the three lowest-ranked signals overflow.
        c.skip = 25'h000_002D;
        l.gpo = 25'h000_0005;
        apply(c, l, "R2 R8");

        // R3: global enable off.
        c.en = 1'b0;
        apply(c, l, "R3");

        // R4: slave select drops out in three-wire mode; lower signals move up.
        c.en = 1'b1; c.skip = '0; c.four = 1'b0;
        apply(c, l, "R4");
        c.sen = 24'h00_0028; c.four = 1'b1;
        apply(c, l, "R4");
        c.four = 1'b0;
        apply(c, l, "R4");

        // R6: analog pins still get claimed but stay silent and read 0.
        c.four = 1'b1; c.sen = '1; c.dig = 25'h1F0_F0F0; l.pin = '1;
        apply(c, l, "R6");

        // R7: mixed drive modes with mixed values and enables.
        c.dig = '1; c.pp = 25'h0AA_AAAA; l.po = 24'h33_CC_55; l.poe = 24'hF0_F0_0F;
        l.gpo = 25'h155_5555;
        apply(c, l, "R7");
        c.pp = '0;
        apply(c, l, "R7");

        // R10: sparse requests (MISO, timer 0, LIN receive) read their pins.
        c.pp = '1; c.sen = 24'h90_0008; c.skip = 25'h000_0003; l.pin = 25'h000_001C;
        apply(c, l, "R10");
        l.pin = 25'h1FF_FFE3;
        apply(c, l, "R10");

        // R11: enabled but nothing requested: whole bank follows gpio_out.
        c.sen = '0; c.skip = '0; l.gpo = 25'h12E_5B3C;
        apply(c, l, "R11");

        // R1: mixed random configurations.
        for (int i = 0; i < 40; i++) begin
            c.en   = ($urandom % 8) != 0;
            c.four = 1'($urandom);
            c.sen  = NS'($urandom);
            c.skip = NP'($urandom) & NP'($urandom);
            c.dig  = NP'($urandom) | NP'($urandom);
            c.pp   = NP'($urandom);
            l.gpo  = NP'($urandom); l.pin = NP'($urandom);
            l.po   = NS'($urandom); l.poe = NS'($urandom);
            apply(c, l, "R1");
        end

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule